// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

The unit turns one decoded operand specifier into an operand value. It takes a mode code, an address field A, a register selector and, for chained indirection, a level count. It then works out where the operand lives, issues as many single-word memory reads as that mode needs, and returns the operand together with its effective address (EA) when the operand is in memory. The modes are immediate, direct, chained indirect, register, register-indirect, displacement, PC-relative, post-index, pre-index, indexed with auto-increment, base update and stack pop. Modes with a register side effect write the new register value back through the register-file write port.

A one-cycle `start_i` pulse, accepted only while the unit is idle, launches a request. `done_o` marks the single cycle in which the results are valid. Memory is one synchronous read port with one cycle of latency. The register file has one combinational read port and one write port. The stack grows downward, and register `SP_SEL` holds the stack pointer.

Top module: `operand_fetch`

## Requirements
- R1: Mode 0 (immediate) returns A as the operand with `ea_valid_o` low and makes no memory read. Undefined codes 13 to 15 behave exactly like mode 0.
- R2: Mode 1 (direct) makes one read at address A. The operand is the word read and the EA is A.
- R3: Mode 2 (chained indirect) reads at A, then at each returned word in turn, for `level_i` pointer levels (0 counts as 1, so 2 to 4 reads). The EA is the last pointer and the operand is the word read there.
- R4: Mode 3 (register) returns the content of the selected register with `ea_valid_o` low and no memory read.
- R5: Mode 4 (register-indirect) makes one read at the content of the selected register, which is also the EA.
- R6: Mode 5 (displacement) uses EA = A + register, and mode 6 (relative) uses EA = A + `pc_i`. Each makes one read at the EA.
- R7: Mode 7 (post-index) reads the word at A and adds the register to it to form the EA. A second read at the EA fetches the operand.
- R8: Mode 8 (pre-index) reads the word at A + register, which is the EA. A second read at the EA fetches the operand.
- R9: Mode 9 (auto-increment) reads the operand at EA = A + register and writes register + 1 back to the selected register.
- R10: Mode 10 (base update) reads the operand at EA = register + sign-extended A[15:0] and writes that EA back to the selected register. A[DW-1:16] is ignored.
- R11: Mode 11 pops one word and mode 12 pops two. `operand_o` is the word at SP and, for mode 12, `operand_b_o` is the word at SP+1. The EA is SP, and register `SP_SEL` is written with SP+1 or SP+2.
- R12: Each read holds `mem_req_o` for one cycle, and its data is taken in the next cycle. `done_o` is a single-cycle pulse, 1 cycle after start for modes without memory reads and 2N+1 cycles after start for N reads. A `start_i` while `busy_o` is high is ignored.
- R13: The register write-back happens only in the `done_o` cycle, at most once per request, and only for modes 9 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| mode_i | input | 4 | Addressing mode code |
| addr_i | input | DW | Address field A |
| rsel_i | input | RW | Register selector |
| level_i | input | 2 | Pointer levels for mode 2 |
| pc_i | input | DW | Current program counter |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Results valid this cycle |
| operand_o | output | DW | Operand (first popped word for mode 12) |
| operand_b_o | output | DW | Second popped word, mode 12 |
| ea_o | output | DW | Effective address, 0 when not valid |
| ea_valid_o | output | 1 | EA is meaningful |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | DW | Memory read address |
| mem_rdata_i | input | DW | Read data, one cycle after the strobe |
| rf_raddr_o | output | RW | Register read select |
| rf_rdata_i | input | DW | Register read data |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | RW | Register write select |
| rf_wdata_o | output | DW | Register write data |

## Verification
A corrupted remaining-read count or next-address selector shows up at the ports right away. The number of `mem_req_o` strobes changes, and `done_o` moves by two cycles for every extra or missing read. A wrong pointer in a chain shows up at the next strobe as a wrong `mem_addr_o`, and by `done_o` as a wrong EA and operand. Side-effect state that is wrong can only be seen in the single `done_o` cycle, as a missing, doubled or misaddressed register write. The register contents are therefore read back after every request.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,  M_DIR  = 4'd1,  M_IND  = 4'd2,  M_REG  = 4'd3,
    M_RIND = 4'd4,  M_DISP = 4'd5,  M_REL  = 4'd6,  M_POST = 4'd7,
    M_PRE  = 4'd8,  M_AINC = 4'd9,  M_BUPD = 4'd10, M_POP1 = 4'd11,
    M_POP2 = 4'd12
  } mode_e;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_DONE} state_e;

  // how the address of the following read is formed from the data just read
  typedef enum logic [1:0] {NX_CHAIN, NX_ADDREG, NX_NEXTWORD} next_e;
endpackage

// File: rtl/opf_plan.sv
module opf_plan
  import opf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int SP_SEL = 7,
  localparam int RW    = $clog2(NREG)
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] a_i,
  input  logic [RW-1:0] rsel_i,
  input  logic [1:0]    level_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] rval_i,
  output logic [RW-1:0] raddr_o,
  output logic [DW-1:0] first_addr_o,
  output logic [2:0]    nreads_o,
  output next_e         nx_o,
  output logic [DW-1:0] imm_opnd_o,
  output logic          ea_valid_o,
  output logic          hold_ea_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_addr_o,
  output logic [DW-1:0] wb_data_o
);
  localparam logic [RW-1:0] SP_IDX = SP_SEL[RW-1:0];

  logic [DW-1:0] disp16;
  logic [1:0]    lvl;
  logic          is_pop;

  assign disp16  = {{(DW-16){a_i[15]}}, a_i[15:0]};
  assign lvl     = (level_i == 2'd0) ? 2'd1 : level_i;
  assign is_pop  = (mode_i == M_POP1) || (mode_i == M_POP2);
  assign raddr_o = is_pop ? SP_IDX : rsel_i;

  always_comb begin
    first_addr_o = a_i;
    nreads_o     = 3'd0;
    nx_o         = NX_CHAIN;
    imm_opnd_o   = a_i;
    ea_valid_o   = 1'b0;
    hold_ea_o    = 1'b0;
    wb_en_o      = 1'b0;
    wb_addr_o    = rsel_i;
    wb_data_o    = '0;
    case (mode_i)
      M_DIR: begin
        nreads_o   = 3'd1;
        ea_valid_o = 1'b1;
      end
      M_IND: begin
        nreads_o   = {1'b0, lvl} + 3'd1;
        ea_valid_o = 1'b1;
      end
      M_REG: imm_opnd_o = rval_i;
      M_RIND: begin
        first_addr_o = rval_i;
        nreads_o     = 3'd1;
        ea_valid_o   = 1'b1;
      end
      M_DISP: begin
        first_addr_o = a_i + rval_i;
        nreads_o     = 3'd1;
        ea_valid_o   = 1'b1;
      end
      M_REL: begin
        first_addr_o = a_i + pc_i;
        nreads_o     = 3'd1;
        ea_valid_o   = 1'b1;
      end
      M_POST: begin
        nreads_o   = 3'd2;
        nx_o       = NX_ADDREG;
        ea_valid_o = 1'b1;
      end
      M_PRE: begin
        first_addr_o = a_i + rval_i;
        nreads_o     = 3'd2;
        ea_valid_o   = 1'b1;
      end
      M_AINC: begin
        first_addr_o = a_i + rval_i;
        nreads_o     = 3'd1;
        ea_valid_o   = 1'b1;
        wb_en_o      = 1'b1;
        wb_data_o    = rval_i + 1'b1;
      end
      M_BUPD: begin
        first_addr_o = rval_i + disp16;
        nreads_o     = 3'd1;
        ea_valid_o   = 1'b1;
        wb_en_o      = 1'b1;
        wb_data_o    = rval_i + disp16;
      end
      M_POP1: begin
        first_addr_o = rval_i;
        nreads_o     = 3'd1;
        ea_valid_o   = 1'b1;
        wb_en_o      = 1'b1;
        wb_addr_o    = SP_IDX;
        wb_data_o    = rval_i + 1'b1;
      end
      M_POP2: begin
        first_addr_o = rval_i;
        nreads_o     = 3'd2;
        nx_o         = NX_NEXTWORD;
        ea_valid_o   = 1'b1;
        hold_ea_o    = 1'b1;
        wb_en_o      = 1'b1;
        wb_addr_o    = SP_IDX;
        wb_data_o    = rval_i + 2'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int DW  = 32,
  parameter int RW  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] first_addr_i,
  input  logic [2:0]    nreads_i,
  input  next_e         nx_i,
  input  logic [DW-1:0] imm_opnd_i,
  input  logic [DW-1:0] rval_i,
  input  logic          ea_valid_i,
  input  logic          hold_ea_i,
  input  logic          wb_en_i,
  input  logic [RW-1:0] wb_addr_i,
  input  logic [DW-1:0] wb_data_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] operand_o,
  output logic [DW-1:0] operand_b_o,
  output logic [DW-1:0] ea_o,
  output logic          ea_valid_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o
);
  state_e        state_q;
  next_e         nx_q;
  logic [DW-1:0] addr_q, radd_q, opnd_q, opnd_b_q, ea_q, wb_data_q;
  logic [2:0]    left_q;
  logic          first_q, eav_q, hold_q, wb_en_q;
  logic [RW-1:0] wb_addr_q;
  logic [DW-1:0] next_addr;

  always_comb begin
    case (nx_q)
      NX_ADDREG:   next_addr = mem_rdata_i + radd_q;
      NX_NEXTWORD: next_addr = addr_q + 1'b1;
      default:     next_addr = mem_rdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      nx_q      <= NX_CHAIN;
      addr_q    <= '0;
      radd_q    <= '0;
      opnd_q    <= '0;
      opnd_b_q  <= '0;
      ea_q      <= '0;
      left_q    <= '0;
      first_q   <= 1'b0;
      eav_q     <= 1'b0;
      hold_q    <= 1'b0;
      wb_en_q   <= 1'b0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q   <= (nreads_i == 3'd0) ? S_DONE : S_REQ;
          nx_q      <= nx_i;
          addr_q    <= first_addr_i;
          radd_q    <= rval_i;
          opnd_q    <= imm_opnd_i;
          opnd_b_q  <= '0;
          ea_q      <= first_addr_i;
          left_q    <= nreads_i;
          first_q   <= 1'b1;
          eav_q     <= ea_valid_i;
          hold_q    <= hold_ea_i;
          wb_en_q   <= wb_en_i;
          wb_addr_q <= wb_addr_i;
          wb_data_q <= wb_data_i;
        end
        S_REQ: begin
          state_q <= S_RSP;
          if (!hold_q) ea_q <= addr_q;
        end
        S_RSP: begin
          if (nx_q == NX_NEXTWORD && !first_q) opnd_b_q <= mem_rdata_i;
          else                                 opnd_q   <= mem_rdata_i;
          addr_q  <= next_addr;
          left_q  <= left_q - 3'd1;
          first_q <= 1'b0;
          state_q <= (left_q == 3'd1) ? S_DONE : S_REQ;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign mem_req_o   = (state_q == S_REQ);
  assign mem_addr_o  = addr_q;
  assign operand_o   = opnd_q;
  assign operand_b_o = opnd_b_q;
  assign ea_valid_o  = eav_q;
  assign ea_o        = eav_q ? ea_q : '0;
  assign rf_we_o     = done_o && wb_en_q;
  assign rf_waddr_o  = wb_addr_q;
  assign rf_wdata_o  = wb_data_q;
endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
  import opf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int SP_SEL = 7,
  localparam int RW    = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] addr_i,
  input  logic [RW-1:0] rsel_i,
  input  logic [1:0]    level_i,
  input  logic [DW-1:0] pc_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] operand_o,
  output logic [DW-1:0] operand_b_o,
  output logic [DW-1:0] ea_o,
  output logic          ea_valid_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o
);
  logic [DW-1:0] first_addr, imm_opnd, wb_data;
  logic [2:0]    nreads;
  next_e         nx;
  logic          ea_valid, hold_ea, wb_en;
  logic [RW-1:0] wb_addr;

  opf_plan #(.DW(DW), .NREG(NREG), .SP_SEL(SP_SEL)) u_plan (
    .mode_i      (mode_i),
    .a_i         (addr_i),
    .rsel_i      (rsel_i),
    .level_i     (level_i),
    .pc_i        (pc_i),
    .rval_i      (rf_rdata_i),
    .raddr_o     (rf_raddr_o),
    .first_addr_o(first_addr),
    .nreads_o    (nreads),
    .nx_o        (nx),
    .imm_opnd_o  (imm_opnd),
    .ea_valid_o  (ea_valid),
    .hold_ea_o   (hold_ea),
    .wb_en_o     (wb_en),
    .wb_addr_o   (wb_addr),
    .wb_data_o   (wb_data)
  );

  opf_seq #(.DW(DW), .RW(RW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .first_addr_i(first_addr),
    .nreads_i    (nreads),
    .nx_i        (nx),
    .imm_opnd_i  (imm_opnd),
    .rval_i      (rf_rdata_i),
    .ea_valid_i  (ea_valid),
    .hold_ea_i   (hold_ea),
    .wb_en_i     (wb_en),
    .wb_addr_i   (wb_addr),
    .wb_data_i   (wb_data),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .operand_o   (operand_o),
    .operand_b_o (operand_b_o),
    .ea_o        (ea_o),
    .ea_valid_o  (ea_valid_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .rf_we_o     (rf_we_o),
    .rf_waddr_o  (rf_waddr_o),
    .rf_wdata_o  (rf_wdata_o)
  );
endmodule

// File: rtl/operand_fetch_chk.sv
module operand_fetch_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [DW-1:0] addr_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ea_valid_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          rf_we_o
);
  AST_IMM_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 4'd0) |=> (!mem_req_o && done_o && !ea_valid_o)); // R1

  AST_DIR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 4'd1) |=> (mem_req_o && mem_addr_o == $past(addr_i))); // R2

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12

  AST_REQ_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o && busy_o)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o)); // R12

  AST_WB_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o); // R13
endmodule

bind operand_fetch operand_fetch_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .addr_i    (addr_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ea_valid_o(ea_valid_o),
  .mem_req_o (mem_req_o),
  .mem_addr_o(mem_addr_o),
  .rf_we_o   (rf_we_o)
);

// File: tb/operand_fetch_tb.sv
module operand_fetch_tb;
  localparam int DW = 32;
  localparam int NREG = 8;
  localparam int RW = 3;
  localparam logic [DW-1:0] PC = 32'h0000_4000;

  typedef struct packed {
    logic [3:0]  m;
    logic [31:0] a;
    logic [2:0]  r;
    logic [1:0]  lv;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'h0000_1234, 3'd0, 2'd0},
    '{4'd1,  32'h0000_0040, 3'd0, 2'd0},
    '{4'd2,  32'h0000_0080, 3'd0, 2'd1},
    '{4'd2,  32'h0000_0084, 3'd0, 2'd2},
    '{4'd2,  32'h0000_0088, 3'd0, 2'd3},
    '{4'd2,  32'h0000_008C, 3'd0, 2'd0},
    '{4'd3,  32'h0000_0000, 3'd3, 2'd0},
    '{4'd4,  32'h0000_0000, 3'd2, 2'd0},
    '{4'd5,  32'h0000_0010, 3'd4, 2'd0},
    '{4'd6,  32'h0000_0020, 3'd0, 2'd0},
    '{4'd7,  32'h0000_0100, 3'd1, 2'd0},
    '{4'd8,  32'h0000_0100, 3'd1, 2'd0},
    '{4'd9,  32'h0000_0200, 3'd5, 2'd0},
    '{4'd10, 32'hFFF0_FFF8, 3'd6, 2'd0},
    '{4'd10, 32'h0000_0100, 3'd0, 2'd0},
    '{4'd11, 32'h0000_0000, 3'd1, 2'd0},
    '{4'd12, 32'h0000_0000, 3'd1, 2'd0},
    '{4'd14, 32'h0000_0077, 3'd3, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [DW-1:0] addr = '0;
  logic [RW-1:0] rsel = '0;
  logic [1:0]    level = '0;
  logic          busy, done, ea_valid, mem_req, rf_we;
  logic [DW-1:0] operand, operand_b, ea, mem_addr, mem_rdata, rf_wdata;
  logic [RW-1:0] rf_raddr, rf_waddr;
  logic [DW-1:0] regs [NREG];

  int tests = 0, fails = 0, cyc = 0;
  int reqs = 0, wes = 0, dones = 0;

  always #4 clk = ~clk;

  operand_fetch #(.DW(DW), .NREG(NREG), .SP_SEL(7)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .addr_i(addr), .rsel_i(rsel), .level_i(level), .pc_i(PC),
    .busy_o(busy), .done_o(done), .operand_o(operand), .operand_b_o(operand_b),
    .ea_o(ea), .ea_valid_o(ea_valid), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .rf_raddr_o(rf_raddr), .rf_rdata_i(regs[rf_raddr]),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata)
  );

  function automatic logic [DW-1:0] memf(input logic [DW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0000_0F00;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      mem_rdata <= memf(mem_addr);
      reqs <= reqs + 1;
    end
    if (done) dones <= dones + 1;
    if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
      wes <= wes + 1;
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    tests++; fails++;
    $display("FAIL watchdog R12: act=%0d cycles exp<100000", cyc);
    finish_run();
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic init_regs();
    for (int i = 0; i < NREG; i++) regs[i] = 32'h1000 * (i + 1) + i;
    regs[7] = 32'h0000_8000;
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      4'd10: return "R10";
      4'd11, 4'd12: return "R11";
      default: return "R1";
    endcase
  endfunction

  // expected results straight from the requirements
  task automatic model(input vec_t v, output logic [DW-1:0] op, output logic [DW-1:0] opb,
                       output logic [DW-1:0] e, output logic ev, output int nr,
                       output logic we, output int wa, output logic [DW-1:0] wd);
    logic [DW-1:0] rv, p;
    int lv;
    rv = regs[v.r];
    op = v.a; opb = '0; e = '0; ev = 1'b0; nr = 0; we = 1'b0; wa = 0; wd = '0;
    case (v.m)
      4'd1: begin e = v.a; nr = 1; end
      4'd2: begin
        lv = (v.lv == 0) ? 1 : int'(v.lv);
        p = v.a;
        for (int k = 0; k < lv; k++) p = memf(p);
        e = p; nr = lv + 1;
      end
      4'd3: op = rv;
      4'd4: begin e = rv; nr = 1; end
      4'd5: begin e = v.a + rv; nr = 1; end
      4'd6: begin e = v.a + PC; nr = 1; end
      4'd7: begin e = memf(v.a) + rv; nr = 2; end
      4'd8: begin e = memf(v.a + rv); nr = 2; end
      4'd9: begin e = v.a + rv; nr = 1; we = 1; wa = v.r; wd = rv + 1; end
      4'd10: begin
        e = rv + {{16{v.a[15]}}, v.a[15:0]}; nr = 1; we = 1; wa = v.r; wd = e;
      end
      4'd11: begin e = regs[7]; nr = 1; we = 1; wa = 7; wd = regs[7] + 1; end
      4'd12: begin
        e = regs[7]; nr = 2; we = 1; wa = 7; wd = regs[7] + 2;
        opb = memf(regs[7] + 1);
      end
      default: ;
    endcase
    if (nr > 0) begin
      ev = 1'b1;
      if (v.m != 4'd12) op = memf(e);
      else              op = memf(e);
    end
  endtask

  task automatic run(input vec_t v, input bit poke_busy);
    logic [DW-1:0] eop, eopb, eea, ewd, pre [NREG];
    logic eev, ewe;
    int enr, ewa, lat, r0, w0, d0;
    string t;
    init_regs();
    model(v, eop, eopb, eea, eev, enr, ewe, ewa, ewd);
    for (int i = 0; i < NREG; i++) pre[i] = regs[i];
    t = tag_of(v.m);
    @(negedge clk);
    r0 = reqs; w0 = wes; d0 = dones;
    mode = v.m; addr = v.a; rsel = v.r; level = v.lv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 40) begin
      if (poke_busy && lat == 2) begin
        mode = 4'd0; addr = 32'hDEAD_0000; start = 1'b1;  // R12: ignored while busy
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    chk(operand == eop, {t, " operand"}, operand, eop);
    if (v.m == 4'd12) chk(operand_b == eopb, "R11 second pop", operand_b, eopb);
    chk(ea_valid == eev && ea == eea, {t, " ea"}, ea, eea);
    chk(lat == ((enr == 0) ? 1 : 2 * enr + 1), "R12 latency", lat, (enr == 0) ? 1 : 2 * enr + 1);
    @(negedge clk);
    chk(done == 1'b0, "R12 single done pulse", done, 0);
    chk(reqs - r0 == enr, {t, " read count"}, reqs - r0, enr);
    chk(dones - d0 == 1, "R12 one done", dones - d0, 1);
    chk(wes - w0 == (ewe ? 1 : 0), "R13 write-back count", wes - w0, ewe ? 1 : 0);
    if (ewe) chk(regs[ewa] == ewd, {t, " write-back value"}, regs[ewa], ewd);
    for (int i = 0; i < NREG; i++)
      if (!(ewe && i == ewa)) chk(regs[i] == pre[i], "R13 other regs kept", regs[i], pre[i]);
  endtask

  initial begin
    init_regs();
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !rf_we, "R12 reset state", {busy, done, mem_req, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R12 idle after reset", {busy, mem_req}, 0);

    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

    // start during a long chain is ignored
    run('{4'd2, 32'h0000_0300, 3'd0, 2'd3}, 1'b1);
    run('{4'd11, 32'h0, 3'd0, 2'd0}, 1'b1);

    // reset in the middle of a request
    @(negedge clk);
    mode = 4'd2; addr = 32'h40; level = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !mem_req && !done, "R12 async reset aborts", {busy, mem_req, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(VECS[1], 1'b0);

    finish_run();
  end
endmodule